// File: doc/BRIEF.md
# Multi-Level Event Sequencer

This block walks through a programmed chain of up to eight levels and raises a single "sequence hit" flag when a level marked as final is entered. At every level it watches one trigger source chosen from a set of complex-event match lines and pass-counter outputs. When the chosen source is high on a clock edge, it jumps to the successor level configured for the current level. The event comparators and the pass counters sit outside this block and only their one-bit outputs arrive here.

The hit flag is latched. It can request a breakpoint, qualify trace capture, and drive an external trigger pin with selectable polarity, and each of these paths has its own enable. A re-arm input sends the sequencer back to level 0 and clears the flag. The per-level configuration (source code, successor level, final flag) comes in on static input vectors. Level `i` occupies bit slice `i*SRC_W +: SRC_W` of the source vector, slice `i*LVL_W +: LVL_W` of the successor vector, and bit `i` of the final vector.

Top module: `event_sequencer`

## Requirements
- R1: While `rst_n` is low on a clock edge, the level becomes 0 and `seq_hit_o`, `brk_req_o` and `trace_qual_o` go low.
- R2: The source code of a level chooses its trigger as follows. Codes 0 to NUM_EVENTS-1 pick `evt_i[code]`. Codes NUM_EVENTS to NUM_EVENTS+NUM_COUNTERS-1 pick `pc_i[code-NUM_EVENTS]`. Every higher code picks nothing, and a level with such a code never advances.
- R3: If the chosen source is high on an edge, the hit flag is low and re-arm is low, the level becomes the successor configured for the current level. Only one step is taken per edge.
- R4: If the chosen source is low, the level and the hit flag hold, whatever the unselected sources do.
- R5: A step into a level whose final flag is set raises `seq_hit_o` on that edge, including a step from a level back to itself. The level 0 state entered by reset or re-arm never raises it on its own.
- R6: While `seq_hit_o` is high and re-arm is low, the level is frozen and the flag stays high, regardless of source or configuration activity.
- R7: Re-arm high on an edge sets the level to 0 and clears `seq_hit_o`, and it takes priority over a pending step.
- R8: `brk_req_o` equals `seq_hit_o` AND `brk_en_i`, and `trace_qual_o` equals `seq_hit_o` AND `trace_en_i`.
- R9: `ext_trig_o` equals (`seq_hit_o` AND `ext_en_i`) XOR `ext_inv_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rearm_i | input | 1 | Return to level 0 and clear the hit flag |
| evt_i | input | NUM_EVENTS | Complex-event match lines |
| pc_i | input | NUM_COUNTERS | Pass-counter outputs |
| cfg_src_i | input | NUM_LEVELS*SRC_W | Per-level trigger source code |
| cfg_next_i | input | NUM_LEVELS*LVL_W | Per-level successor level |
| cfg_final_i | input | NUM_LEVELS | Per-level final flag |
| brk_en_i | input | 1 | Enable for the breakpoint request |
| trace_en_i | input | 1 | Enable for the trace qualifier |
| ext_en_i | input | 1 | Enable for the external trigger pin |
| ext_inv_i | input | 1 | Invert the external trigger pin |
| level_o | output | LVL_W | Current level |
| seq_hit_o | output | 1 | Latched sequence hit |
| brk_req_o | output | 1 | Breakpoint request |
| trace_qual_o | output | 1 | Trace capture qualifier |
| ext_trig_o | output | 1 | External trigger pin level |

## Verification
The hardest situation to reach is a complete walk to a final level under a random configuration. Successor fields can form loops that skip the final level, and codes with no source can stall a level forever, so a random program often never fires. The stimulus therefore reprograms the configuration and re-arms every hundred cycles, mixes sparse random source activity with forced all-high bursts, and always marks at least one level as final. Directed sequences add the cases random runs seldom produce: a self-loop into a final level, re-arm arriving together with a trigger, and a final flag on level 0 at reset.

// File: rtl/seq_pkg.sv
// Package: shared types for the event sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package seq_pkg;

    // Enables for the three consumers of the hit flag
    typedef struct packed {
        logic brk;
        logic trace;
        logic ext;
        logic ext_inv;
    } seq_route_t;

endpackage

// File: rtl/seq_src_mux.sv
// Module: seq_src_mux
// Picks one trigger line out of the event and pass-counter inputs.
// Codes below NUM_EVENTS pick an event, the next NUM_COUNTERS codes pick a
// counter, and any code above those picks a constant zero.
// Assumes: SRC_W is wide enough to hold NUM_EVENTS+NUM_COUNTERS+1 codes.
module seq_src_mux #(
    parameter int NUM_EVENTS   = 5,
    parameter int NUM_COUNTERS = 2,
    parameter int SRC_W        = 3
) (
    input  logic [NUM_EVENTS-1:0]   evt_i,
    input  logic [NUM_COUNTERS-1:0] pc_i,
    input  logic [SRC_W-1:0]        code_i,
    output logic                    trig_o
);

    localparam int NUM_SRC  = NUM_EVENTS + NUM_COUNTERS;
    localparam int SRC_SPAN = 1 << SRC_W;

    logic [SRC_SPAN-1:0] padded;

    // Build a full-width source vector, zero for unused codes
    for (genvar g = 0; g < SRC_SPAN; g++) begin : g_pad
        if (g < NUM_EVENTS) begin : g_evt
            assign padded[g] = evt_i[g];
        end else if (g < NUM_SRC) begin : g_pc
            assign padded[g] = pc_i[g-NUM_EVENTS];
        end else begin : g_none
            assign padded[g] = 1'b0;
        end
    end

    // Index the selected line
    assign trig_o = padded[code_i];

endmodule

// File: rtl/seq_level_fsm.sv
// Module: seq_level_fsm
// Holds the current level and the latched hit flag. The module advances one
// level per edge when the selected trigger is high, and latches the hit flag
// when the level it steps into is marked final.
// Assumes: NUM_LEVELS is a power of two, so every successor code is valid.
module seq_level_fsm #(
    parameter int NUM_LEVELS = 8,
    parameter int LVL_W      = 3,
    parameter int SRC_W      = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rearm_i,
    input  logic                        trig_i,
    input  logic [NUM_LEVELS*SRC_W-1:0] cfg_src_i,
    input  logic [NUM_LEVELS*LVL_W-1:0] cfg_next_i,
    input  logic [NUM_LEVELS-1:0]       cfg_final_i,
    output logic [LVL_W-1:0]            level_o,
    output logic [SRC_W-1:0]            src_code_o,
    output logic                        done_o
);

    logic [SRC_W-1:0] src_arr  [NUM_LEVELS];
    logic [LVL_W-1:0] next_arr [NUM_LEVELS];
    logic [LVL_W-1:0] lvl_q;
    logic [LVL_W-1:0] nxt_lvl;
    logic             done_q;
    logic             step;

    // Unpack the flat configuration vectors into per-level fields
    for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_unpack
        assign src_arr[i]  = cfg_src_i[i*SRC_W +: SRC_W];
        assign next_arr[i] = cfg_next_i[i*LVL_W +: LVL_W];
    end

    assign nxt_lvl    = next_arr[lvl_q];
    assign src_code_o = src_arr[lvl_q];
    assign step       = trig_i & ~done_q;

    // Level and hit-flag register; reset and re-arm take priority
    always_ff @(posedge clk) begin
        if (!rst_n || rearm_i) begin
            lvl_q  <= '0;
            done_q <= 1'b0;
        end else if (step) begin
            lvl_q  <= nxt_lvl;
            done_q <= cfg_final_i[nxt_lvl];
        end
    end

    assign level_o = lvl_q;
    assign done_o  = done_q;

    // R3: a trigger moves the level to the successor chosen in that cycle
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!rearm_i && !done_q && trig_i) |=> (lvl_q == $past(nxt_lvl)));

    // R4: no trigger, no movement
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!rearm_i && !trig_i) |=> ($stable(lvl_q) && $stable(done_q)));

    // R5: stepping into a final level raises the flag
    a_r5_final: assert property (@(posedge clk) disable iff (!rst_n)
        (!rearm_i && !done_q && trig_i && cfg_final_i[nxt_lvl]) |=> done_q);

    // R6: once hit, frozen until re-arm
    a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!rearm_i && done_q) |=> (done_q && $stable(lvl_q)));

    // R7: re-arm returns to level 0 with the flag clear
    a_r7_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        rearm_i |=> ((lvl_q == '0) && !done_q));

endmodule

// File: rtl/seq_out_gen.sv
// Module: seq_out_gen
// Fans the latched hit flag out to the breakpoint, trace and external pin
// paths, each with its own enable. The external pin can be inverted.
// Assumes: the hit flag is a registered signal, so outputs are glitch-free
// apart from changes on the enables.
module seq_out_gen
    import seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit_i,
    input  seq_route_t route_i,
    output logic       seq_o,
    output logic       brk_o,
    output logic       trace_o,
    output logic       ext_o
);

    // Gate the hit flag per consumer
    always_comb begin
        seq_o   = hit_i;
        brk_o   = hit_i & route_i.brk;
        trace_o = hit_i & route_i.trace;
        ext_o   = (hit_i & route_i.ext) ^ route_i.ext_inv;
    end

    // R8: a breakpoint request or trace qualifier implies a hit
    a_r8_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_o || trace_o) |-> seq_o);

    // R9: with the pin disabled it sits at the polarity level
    a_r9_pin_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !route_i.ext |-> (ext_o == route_i.ext_inv));

endmodule

// File: rtl/event_sequencer.sv
// Module: event_sequencer (top)
// Multi-level hardware event sequencer: per-level source selection, level
// state machine and output fan-out.
// Assumes: configuration inputs are quasi-static; a change takes effect at
// the next edge.
module event_sequencer
    import seq_pkg::*;
#(
    parameter int NUM_LEVELS   = 8,
    parameter int NUM_EVENTS   = 5,
    parameter int NUM_COUNTERS = 2,
    parameter int LVL_W        = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1,
    parameter int SRC_W        = $clog2(NUM_EVENTS + NUM_COUNTERS + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rearm_i,
    input  logic [NUM_EVENTS-1:0]       evt_i,
    input  logic [NUM_COUNTERS-1:0]     pc_i,
    input  logic [NUM_LEVELS*SRC_W-1:0] cfg_src_i,
    input  logic [NUM_LEVELS*LVL_W-1:0] cfg_next_i,
    input  logic [NUM_LEVELS-1:0]       cfg_final_i,
    input  logic                        brk_en_i,
    input  logic                        trace_en_i,
    input  logic                        ext_en_i,
    input  logic                        ext_inv_i,
    output logic [LVL_W-1:0]            level_o,
    output logic                        seq_hit_o,
    output logic                        brk_req_o,
    output logic                        trace_qual_o,
    output logic                        ext_trig_o
);

    logic [SRC_W-1:0] cur_code;
    logic             trig;
    logic             hit;
    seq_route_t       route;

    // Collect the output enables into one bundle
    assign route = '{brk: brk_en_i, trace: trace_en_i, ext: ext_en_i, ext_inv: ext_inv_i};

    seq_src_mux #(
        .NUM_EVENTS   (NUM_EVENTS),
        .NUM_COUNTERS (NUM_COUNTERS),
        .SRC_W        (SRC_W)
    ) u_mux (
        .evt_i  (evt_i),
        .pc_i   (pc_i),
        .code_i (cur_code),
        .trig_o (trig)
    );

    seq_level_fsm #(
        .NUM_LEVELS (NUM_LEVELS),
        .LVL_W      (LVL_W),
        .SRC_W      (SRC_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .rearm_i     (rearm_i),
        .trig_i      (trig),
        .cfg_src_i   (cfg_src_i),
        .cfg_next_i  (cfg_next_i),
        .cfg_final_i (cfg_final_i),
        .level_o     (level_o),
        .src_code_o  (cur_code),
        .done_o      (hit)
    );

    seq_out_gen u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit_i   (hit),
        .route_i (route),
        .seq_o   (seq_hit_o),
        .brk_o   (brk_req_o),
        .trace_o (trace_qual_o),
        .ext_o   (ext_trig_o)
    );

endmodule

// File: tb/event_sequencer_test.sv
`timescale 1ns/1ps
module event_sequencer_test;

    localparam int NL = 8;
    localparam int NE = 5;
    localparam int NC = 2;
    localparam int LW = 3;
    localparam int SW = 3;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               rearm = 1'b0;
    logic [NE-1:0]      evt = '0;
    logic [NC-1:0]      pc = '0;
    logic [NL*SW-1:0]   cfg_src;
    logic [NL*LW-1:0]   cfg_next;
    logic [NL-1:0]      cfg_fin = '0;
    logic               brk_en = 1'b0, trace_en = 1'b0, ext_en = 1'b0, ext_inv = 1'b0;
    logic [LW-1:0]      level;
    logic               hit, brk, trc, ext;

    logic [SW-1:0]      m_src  [NL];
    logic [LW-1:0]      m_next [NL];
    logic [LW-1:0]      m_lvl;
    logic               m_done;
    int                 checks = 0;
    int                 errors = 0;
    bit                 finished = 0;

    always #2 clk = ~clk;

    // Pack the bench configuration into the flat vectors
    always_comb begin
        for (int i = 0; i < NL; i++) begin
            cfg_src[i*SW +: SW]  = m_src[i];
            cfg_next[i*LW +: LW] = m_next[i];
        end
    end

    event_sequencer uut (
        .clk(clk), .rst_n(rst_n), .rearm_i(rearm), .evt_i(evt), .pc_i(pc),
        .cfg_src_i(cfg_src), .cfg_next_i(cfg_next), .cfg_final_i(cfg_fin),
        .brk_en_i(brk_en), .trace_en_i(trace_en), .ext_en_i(ext_en), .ext_inv_i(ext_inv),
        .level_o(level), .seq_hit_o(hit), .brk_req_o(brk), .trace_qual_o(trc),
        .ext_trig_o(ext)
    );

    // Source selection per R2
    function automatic logic sel_src(input logic [SW-1:0] code, input logic [NE-1:0] e,
                                     input logic [NC-1:0] p);
        int c = int'(code);
        if (c < NE) return e[c];
        if (c < NE + NC) return p[c-NE];
        return 1'b0;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_outputs(input string tag);
        chk(tag, int'(level), int'(m_lvl));
        chk(tag, int'(hit), int'(m_done));
        chk("R8", int'(brk), int'(m_done & brk_en));
        chk("R8", int'(trc), int'(m_done & trace_en));
        chk("R9", int'(ext), int'((m_done & ext_en) ^ ext_inv));
    endtask

    // One cycle: drive at a falling edge, update model, check at the next falling edge
    task automatic step(input logic [NE-1:0] e, input logic [NC-1:0] p, input logic ra,
                        input string tag);
        evt = e; pc = p; rearm = ra;
        if (ra) begin
            m_lvl = '0; m_done = 1'b0;
        end else if (!m_done && sel_src(m_src[m_lvl], e, p)) begin
            m_lvl  = m_next[m_lvl];
            m_done = cfg_fin[m_lvl];
        end
        @(negedge clk);
        check_outputs(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung run, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NL; i++) begin
            m_src[i] = 3'd7; m_next[i] = LW'((i + 1) % NL);
        end
        cfg_fin = 8'b0000_0001;  // level 0 final: must not fire at reset (R5)
        m_lvl = '0; m_done = 1'b0;
        repeat (3) @(negedge clk);
        brk_en = 1; trace_en = 1; ext_en = 1;
        @(negedge clk);
        check_outputs("R1");
        rst_n = 1'b1;
        step('1, '1, 0, "R2");       // code 7 at level 0: nothing selected
        chk("R5", int'(hit), 0);

        // Chain 0 -(evt0)-> 1 -(pc0)-> 2 final
        m_src[0] = 3'd0; m_src[1] = 3'd5; m_src[2] = 3'd7;
        m_next[0] = 3'd1; m_next[1] = 3'd2;
        cfg_fin = 8'b0000_0100;
        step(5'b11110, 2'b11, 0, "R4");  // only unselected lines high
        chk("R4", int'(level), 0);
        step(5'b00001, 2'b00, 0, "R3");
        chk("R3", int'(level), 1);
        step(5'b11111, 2'b10, 0, "R2");  // pc1 is not pc0
        chk("R2", int'(level), 1);
        step(5'b00000, 2'b01, 0, "R5");
        chk("R5", int'(hit), 1);
        m_next[2] = 3'd5; cfg_fin = 8'hFF;
        step('1, '1, 0, "R6");
        chk("R6", int'(level), 2);
        step('1, '1, 1, "R7");           // re-arm beats trigger
        chk("R7", int'(level), 0);
        chk("R7", int'(hit), 0);

        // Self-loop into a final level 0
        m_src[0] = 3'd4; m_next[0] = 3'd0; cfg_fin = 8'b0000_0001;
        step(5'b10000, 2'b00, 0, "R5");
        chk("R5", int'(hit), 1);
        ext_inv = 1; ext_en = 0; brk_en = 0;
        step('0, '0, 0, "R9");
        chk("R9", int'(ext), 1);
        step('0, '0, 1, "R7");

        // Random rounds: new program, re-arm, then mixed activity
        for (int r = 0; r < 40; r++) begin
            for (int i = 0; i < NL; i++) begin
                m_src[i]  = SW'($urandom % 8);
                m_next[i] = LW'($urandom % NL);
            end
            cfg_fin = NL'($urandom & $urandom & $urandom);
            cfg_fin[$urandom % NL] = 1'b1;
            step('0, '0, 1, "R7");
            for (int k = 0; k < 100; k++) begin
                logic [NE-1:0] e;
                logic [NC-1:0] p;
                brk_en = 1'($urandom); trace_en = 1'($urandom);
                ext_en = 1'($urandom); ext_inv = 1'($urandom);
                if ((k % 17) == 16) begin
                    e = '1; p = '1;
                end else begin
                    e = NE'($urandom & $urandom);
                    p = NC'($urandom & $urandom);
                end
                step(e, p, ($urandom % 64) == 0, "R3");
            end
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule